// File: doc/BRIEF.md
# Quadword Byte Lane Extract, Clear and Place Unit

This unit performs one of three byte-granular operations on a 64-bit data word, so that software can build a single-byte store from aligned quadword loads and stores. A lane number from 0 to 7 comes from the three lowest bits of a separate 64-bit address operand. The rest of that operand is ignored. Lane 0 is the least significant byte.

In pick mode the chosen byte is returned in lane 0 and all other bits are zero. In clear mode the word is returned with the chosen byte set to zero. In place mode the low byte of the word is moved into the chosen lane and every other lane is zero. A fourth code passes the word through unchanged. A byte store is built in three steps: clear the target lane of the destination quadword, place the source byte at the same lane, then OR the two results.

A request is taken on any cycle where the input valid is high. Its result is registered and appears one clock later, together with a registered valid flag.

Top module: `bytelane_unit`

## Requirements
- R1: Only addr_in[2:0] selects the lane (0 to 7). Changing addr_in[63:3] never changes the result.
- R2: Operation code 2'b00 (pick) gives result[7:0] equal to byte lane `lane` of data_in, and result[63:8] equal to zero. For example, 0x0123456789ABCDEF with lane 3 gives 0x89.
- R3: Operation code 2'b01 (clear) gives data_in with lane `lane` set to 0x00 and all other lanes unchanged. For example, 0xFFEEDDCCBBAA9988 with lane 5 gives 0xFFEE00CCBBAA9988.
- R4: Operation code 2'b10 (place) gives data_in[7:0] in lane `lane` and zero in all other lanes.
- R5: Operation code 2'b11 gives data_in unchanged.
- R6: Lane k occupies bits 8k+7 down to 8k, so lane 0 is the least significant byte.
- R7: res_valid equals in_valid from the previous cycle, and result holds the outcome of the request accepted in that previous cycle.
- R8: A synchronous, active-high reset clears res_valid to 0 and result to 0.
- R9: For every lane a, place(x, a) OR clear(y, a) equals y with lane a replaced by x[7:0].
- R10: The result register keeps its value on any cycle where in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| op | input | 2 | Operation code |
| data_in | input | 64 | Quadword operand |
| addr_in | input | 64 | Address operand; bits 2:0 select the lane |
| res_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after its request is presented, whatever the operation. The bench drives inputs on the falling edge, waits for the next rising edge and then half a period, and compares at that point. The byte-store check in R9 chains two requests and ORs the two sampled results in the bench. The hold and reset checks sample on the cycle right after the stimulus, before any new request can change the output.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
  localparam int DATA_W = 64;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int SEL_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_PICK  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_PLACE = 2'b10,
    OP_PASS  = 2'b11
  } bl_op_e;
endpackage

// File: rtl/bytelane_decode.sv
module bytelane_decode #(
  parameter int LANES = 8,
  parameter int SEL_W = $clog2(LANES),
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  sel,
  output logic [LANES-1:0]  onehot
);
  assign sel = addr[SEL_W-1:0];
  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign onehot[k] = (sel == SEL_W'(k));
  end
endmodule

// File: rtl/bytelane_datapath.sv
module bytelane_datapath
  import bytelane_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES,
  parameter int SW = $clog2(NL),
  localparam int DW = LW * NL
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] data,
  input  logic [SW-1:0] sel,
  input  logic [NL-1:0] onehot,
  output logic [DW-1:0] res
);
  logic [LW-1:0] picked;
  logic [DW-1:0] cleared, placed;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NL; k++)
      if (sel == SW'(k)) picked = data[k*LW +: LW];
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign cleared[k*LW +: LW] = onehot[k] ? '0 : data[k*LW +: LW];
    assign placed[k*LW +: LW]  = onehot[k] ? data[LW-1:0] : '0;
  end

  always_comb begin
    unique case (op)
      2'b00:   res = {{(DW-LW){1'b0}}, picked};
      2'b01:   res = cleared;
      2'b10:   res = placed;
      default: res = data;
    endcase
  end
endmodule

// File: rtl/bytelane_unit.sv
module bytelane_unit
  import bytelane_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES,
  localparam int DW = LW * NL,
  localparam int SW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] addr_in,
  output logic          res_valid,
  output logic [DW-1:0] result
);
  logic [SW-1:0] sel;
  logic [NL-1:0] onehot;
  logic [DW-1:0] res_c;

  bytelane_decode #(.LANES(NL), .SEL_W(SW), .ADDR_W(DW)) u_dec (
    .addr(addr_in), .sel(sel), .onehot(onehot));

  bytelane_datapath #(.LW(LW), .NL(NL), .SW(SW)) u_dp (
    .op(op), .data(data_in), .sel(sel), .onehot(onehot), .res(res_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= res_c;
    end
  end
endmodule

// File: rtl/bytelane_checker.sv
module bytelane_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    op,
  input logic [DW-1:0] data_in,
  input logic [DW-1:0] addr_in,
  input logic          res_valid,
  input logic [DW-1:0] result
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_pick_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> (result[DW-1:8] == '0));
  assert_place_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && data_in[7:0] != 8'h00) |=> ($countones(result) == $countones($past(data_in[7:0]))));
  assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> (result == $past(data_in)));
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!res_valid && result == '0));
endmodule

bind bytelane_unit bytelane_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .data_in(data_in),
  .addr_in(addr_in), .res_valid(res_valid), .result(result));

// File: tb/bytelane_unit_test.sv
`timescale 1ns/1ps
module bytelane_unit_test;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] op = 0;
  logic [63:0] data_in = 0, addr_in = 0;
  logic res_valid;
  logic [63:0] result;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bytelane_unit uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .data_in(data_in), .addr_in(addr_in), .res_valid(res_valid), .result(result));

  // {op, data, addr, expected}
  localparam logic [193:0] VEC [10] = '{
    {2'b00, 64'h0123456789ABCDEF, 64'h0000000000000103, 64'h0000000000000089}, // R2
    {2'b01, 64'hFFEEDDCCBBAA9988, 64'h000000000000020D, 64'hFFEE00CCBBAA9988}, // R3
    {2'b00, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFF8, 64'h00000000000000EF}, // R1 R6 lane0
    {2'b00, 64'h0123456789ABCDEF, 64'h0000000000000007, 64'h0000000000000001}, // R6 lane7
    {2'b01, 64'h1122334455667788, 64'hABCDEF0000000000, 64'h1122334455667700}, // R1
    {2'b01, 64'h1122334455667788, 64'h0000000000000007, 64'h0022334455667788}, // R3
    {2'b10, 64'hFFFFFFFFFFFFFF89, 64'h000000000000020D, 64'h0000890000000000}, // R4
    {2'b10, 64'h00000000000000A5, 64'h8000000000000000, 64'h00000000000000A5}, // R4 R1
    {2'b10, 64'h00000000000000A5, 64'h0000000000000007, 64'hA500000000000000}, // R4
    {2'b11, 64'hDEADBEEF01234567, 64'h0000000000000005, 64'hDEADBEEF01234567}  // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [63:0] d, input logic [63:0] a,
                       output logic [63:0] r);
    @(negedge clk);
    op = o; data_in = d; addr_in = a; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    r = result;
    chk("R7", {63'd0, res_valid}, 64'd1);
  endtask

  initial begin
    logic [63:0] r, r1, r2, yexp;
    repeat (2) @(negedge clk);
    chk("R8", result, 64'd0);
    chk("R8", {63'd0, res_valid}, 64'd0);
    rst = 0;
    for (int i = 0; i < 10; i++) begin
      issue(VEC[i][193:192], VEC[i][191:128], VEC[i][127:64], r);
      chk("R2..R6 vector", r, VEC[i][63:0]);
    end
    // R10 hold and R7 idle valid
    issue(2'b11, 64'h5555AAAA5555AAAA, 64'd0, r);
    @(negedge clk);
    data_in = 64'h1; op = 2'b00;
    @(negedge clk);
    chk("R10", result, 64'h5555AAAA5555AAAA);
    chk("R7", {63'd0, res_valid}, 64'd0);
    // R9 byte store for every lane
    for (int a = 0; a < 8; a++) begin
      issue(2'b10, 64'h00000000000000C3 | (64'h1234 << 8), 64'(a) | 64'hF0, r1);
      issue(2'b01, 64'h8877665544332211, 64'(a), r2);
      yexp = 64'h8877665544332211;
      yexp[a*8 +: 8] = 8'hC3;
      chk("R9", r1 | r2, yexp);
    end
    // R8 reset mid-run
    issue(2'b11, 64'hFFFF, 64'd0, r);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R8", result, 64'd0);
    chk("R8", {63'd0, res_valid}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule